// File: doc/BRIEF.md
# Serial Configuration Load Sequencer

This block loads a configuration image into a programmable target device through its slave-serial configuration port. A single start request makes it run the whole sequence. It first pulls the active-low program line down for a set number of system clock cycles and then releases it. Next it waits, for a bounded time, for the target's init-ready input to go high. It then shifts out a given number of bytes, one bit per configuration clock pulse. When the last byte is gone, it keeps pulsing the configuration clock until the target raises its done input, again for a bounded time.

The image arrives as a byte stream with a valid/ready handshake. The stream carries an error flag as well. A byte marked as an error ends the data phase early, and the sequencer moves straight on to the done wait. The init and done pins of the target pass through two-flop synchronisers. Busy, success and error flags show where the sequence stands. Success and error stay set until the next start.

Top module: `cfg_loader`

## Requirements
- R1: After reset and while idle, prog_n_o is 1, cclk_o is 0 and din_o is 0. After reset, busy_o, success_o and error_o are 0.
- R2: A start_i seen while idle raises busy_o on the next cycle and clears success_o and error_o. prog_n_o is then low for exactly PROG_HOLD cycles, once per start.
- R3: No configuration clock pulse is made before init_i is seen high. If init_i stays low for INIT_LIMIT cycles after prog_n_o is released, error_o is set, busy_o drops and no byte is taken.
- R4: Each byte is sent most significant bit first. din_o is set while cclk_o is low and is stable at each rising edge of cclk_o. cclk_o stays high for HALF_PER cycles per pulse.
- R5: Exactly byte_len_i bytes are taken from the stream, one per handshake (byte_valid_i and byte_ready_o both 1 at a clock edge), and each byte gives eight clock pulses.
- R6: After the data phase, clock pulses go on until done_i is seen high. The sequencer then sets success_o and drops busy_o.
- R7: If done_i stays low, the sequencer makes exactly DONE_LIMIT extra clock pulses after the data phase. It then sets error_o and drops busy_o. success_o and error_o are never both 1.
- R8: A byte taken with byte_err_i = 1 is not sent. No further bytes are taken, and the sequencer goes straight to the done wait.
- R9: start_i has no effect while busy_o is 1. There is no second program pulse, and the bytes sent do not change.
- R10: With byte_len_i = 0 no byte is taken, and the sequencer goes straight from the init wait to the done wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| byte_len_i | input | LEN_W | Number of image bytes, sampled with start |
| byte_valid_i | input | 1 | Stream byte available |
| byte_data_i | input | 8 | Stream byte |
| byte_err_i | input | 1 | Stream byte marks an upstream error |
| byte_ready_o | output | 1 | Sequencer takes a byte this cycle |
| init_i | input | 1 | Target init-ready pin (asynchronous) |
| done_i | input | 1 | Target done pin (asynchronous) |
| prog_n_o | output | 1 | Active-low program line to target |
| cclk_o | output | 1 | Configuration clock to target |
| din_o | output | 1 | Configuration data to target |
| busy_o | output | 1 | Sequence in progress |
| success_o | output | 1 | Last sequence ended with done seen |
| error_o | output | 1 | Last sequence timed out |

## Verification
busy_o is due one cycle after start_i. prog_n_o then stays low for exactly PROG_HOLD cycles, and the bench counts this exactly, one sample per cycle. The init timeout lands exactly INIT_LIMIT cycles after the program release, and the done timeout lands after exactly DONE_LIMIT extra pulses. Both are counted at the ports. The success case is different: the two-flop synchroniser adds a delay of up to two cycles, plus part of a clock half period. So the bench accepts a window of at most two extra pulses there. All outputs are sampled one nanosecond after the falling clock edge, and the bench waits a few cycles after busy_o falls before it compares the counts.

// File: rtl/cfgl_pkg.sv
`timescale 1ns/1ps
package cfgl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_WINIT,
        ST_FETCH,
        ST_BLO,
        ST_BHI,
        ST_DLO,
        ST_DHI
    } cfgl_state_e;
endpackage

// File: rtl/cfgl_sync.sv
`timescale 1ns/1ps
module cfgl_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/cfgl_pacer.sv
`timescale 1ns/1ps
module cfgl_pacer #(
    parameter int PERIOD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfgl_budget.sv
`timescale 1ns/1ps
module cfgl_budget #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last_o = (cnt_q == LAST);
        if (clr_i)                cnt_d = '0;
        else if (inc_i && !last_o) cnt_d = cnt_q + 1'b1;
        else                       cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader
    import cfgl_pkg::*;
#(
    parameter int PROG_HOLD  = 1200,
    parameter int HALF_PER   = 3,
    parameter int INIT_LIMIT = 100000,
    parameter int DONE_LIMIT = 100000,
    parameter int LEN_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] byte_len_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_data_i,
    input  logic             byte_err_i,
    output logic             byte_ready_o,
    input  logic             init_i,
    input  logic             done_i,
    output logic             prog_n_o,
    output logic             cclk_o,
    output logic             din_o,
    output logic             busy_o,
    output logic             success_o,
    output logic             error_o
);
    localparam int BW = 8;
    localparam int IW = $clog2(BW);

    typedef struct packed {
        cfgl_state_e      state;
        logic [LEN_W-1:0] left;
        logic [BW-1:0]    shreg;
        logic [IW-1:0]    bit_idx;
        logic             prog_n;
        logic             cclk;
        logic             din;
        logic             busy;
        logic             success;
        logic             error;
    } cfgl_regs_t;

    cfgl_regs_t r_d, r_q;

    logic [1:0] pins_s;
    logic       init_s, done_s;
    logic       tick, hold_last, init_last, done_last;
    logic       pace_run;

    cfgl_sync #(.W(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({done_i, init_i}),
        .q_o  (pins_s)
    );
    assign init_s = pins_s[0];
    assign done_s = pins_s[1];

    assign pace_run = (r_q.state == ST_BLO) || (r_q.state == ST_BHI) ||
                      (r_q.state == ST_DLO) || (r_q.state == ST_DHI);

    cfgl_pacer #(.PERIOD(HALF_PER)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (pace_run),
        .tick_o(tick)
    );

    cfgl_budget #(.LIMIT(PROG_HOLD)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (r_q.state != ST_PROG),
        .inc_i (1'b1),
        .last_o(hold_last)
    );

    cfgl_budget #(.LIMIT(INIT_LIMIT)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (r_q.state != ST_WINIT),
        .inc_i (!init_s),
        .last_o(init_last)
    );

    cfgl_budget #(.LIMIT(DONE_LIMIT)) u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (!((r_q.state == ST_DLO) || (r_q.state == ST_DHI))),
        .inc_i ((r_q.state == ST_DHI) && tick),
        .last_o(done_last)
    );

    assign byte_ready_o = (r_q.state == ST_FETCH) && (r_q.left != '0);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state   = ST_PROG;
                    r_d.prog_n  = 1'b0;
                    r_d.busy    = 1'b1;
                    r_d.success = 1'b0;
                    r_d.error   = 1'b0;
                    r_d.left    = byte_len_i;
                end
            end
            ST_PROG: begin
                if (hold_last) begin
                    r_d.state  = ST_WINIT;
                    r_d.prog_n = 1'b1;
                end
            end
            ST_WINIT: begin
                if (init_s) begin
                    r_d.state = ST_FETCH;
                end else if (init_last) begin
                    r_d.state = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.error = 1'b1;
                end
            end
            ST_FETCH: begin
                if (r_q.left == '0) begin
                    r_d.state = ST_DLO;
                    r_d.din   = 1'b0;
                end else if (byte_valid_i) begin
                    if (byte_err_i) begin
                        r_d.state = ST_DLO;
                        r_d.din   = 1'b0;
                    end else begin
                        r_d.state   = ST_BLO;
                        r_d.shreg   = byte_data_i;
                        r_d.din     = byte_data_i[BW-1];
                        r_d.bit_idx = IW'(BW - 1);
                    end
                end
            end
            ST_BLO: begin
                if (tick) begin
                    r_d.state = ST_BHI;
                    r_d.cclk  = 1'b1;
                end
            end
            ST_BHI: begin
                if (tick) begin
                    r_d.cclk = 1'b0;
                    if (r_q.bit_idx == '0) begin
                        r_d.state = ST_FETCH;
                        r_d.left  = r_q.left - 1'b1;
                    end else begin
                        r_d.state   = ST_BLO;
                        r_d.shreg   = {r_q.shreg[BW-2:0], 1'b0};
                        r_d.din     = r_q.shreg[BW-2];
                        r_d.bit_idx = r_q.bit_idx - 1'b1;
                    end
                end
            end
            ST_DLO: begin
                if (done_s) begin
                    r_d.state   = ST_IDLE;
                    r_d.busy    = 1'b0;
                    r_d.success = 1'b1;
                end else if (tick) begin
                    r_d.state = ST_DHI;
                    r_d.cclk  = 1'b1;
                end
            end
            ST_DHI: begin
                if (tick) begin
                    r_d.cclk = 1'b0;
                    if (done_last) begin
                        r_d.state = ST_IDLE;
                        r_d.busy  = 1'b0;
                        r_d.error = 1'b1;
                    end else begin
                        r_d.state = ST_DLO;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.prog_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign prog_n_o  = r_q.prog_n;
    assign cclk_o    = r_q.cclk;
    assign din_o     = r_q.din;
    assign busy_o    = r_q.busy;
    assign success_o = r_q.success;
    assign error_o   = r_q.error;
endmodule

// File: rtl/cfgl_checks.sv
`timescale 1ns/1ps
module cfgl_checks (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_ready_o,
    input logic prog_n_o,
    input logic cclk_o,
    input logic din_o,
    input logic busy_o,
    input logic success_o,
    input logic error_o
);
    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (prog_n_o && !cclk_o && !din_o)); // R1

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> !cclk_o); // R3

    AST_DIN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $stable(din_o)); // R4

    AST_READY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> (busy_o && !cclk_o && prog_n_o)); // R5

    AST_BUSY_FLAGS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!success_o && !error_o)); // R6

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(success_o && error_o)); // R7

    AST_PROG_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && $past(prog_n_o)) |-> prog_n_o); // R9
endmodule

bind cfg_loader cfgl_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_ready_o(byte_ready_o),
    .prog_n_o    (prog_n_o),
    .cclk_o      (cclk_o),
    .din_o       (din_o),
    .busy_o      (busy_o),
    .success_o   (success_o),
    .error_o     (error_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;
    localparam int PH = 5;
    localparam int HP = 2;
    localparam int IL = 40;
    localparam int DL = 30;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] byte_len_i = '0;
    logic          byte_ready_o;
    logic          byte_valid_i;
    logic [7:0]    byte_data_i;
    logic          byte_err_i;
    logic          init_i = 1'b0;
    logic          done_i = 1'b0;
    logic          prog_n_o, cclk_o, din_o, busy_o, success_o, error_o;

    always #4 clk = ~clk;

    cfg_loader #(.PROG_HOLD(PH), .HALF_PER(HP), .INIT_LIMIT(IL),
                 .DONE_LIMIT(DL), .LEN_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_len_i(byte_len_i),
        .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_err_i(byte_err_i), .byte_ready_o(byte_ready_o),
        .init_i(init_i), .done_i(done_i), .prog_n_o(prog_n_o),
        .cclk_o(cclk_o), .din_o(din_o), .busy_o(busy_o),
        .success_o(success_o), .error_o(error_o));

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] src_mem [16];
    int  src_idx = 0, src_base = 0, err_pos = -1;
    bit  pend = 0;
    int  pulses = 0, nbits = 0, prog_low = 0, prog_falls = 0, wait_cnt = 0;
    int  phi = 0, hi_run = 0, hi_min = 1000, hi_max = 0;
    bit  cclk_prev = 0, prog_prev = 1;
    bit  init_en = 1, done_en = 0;
    int  done_base = 0, done_after = 0;
    logic bits [512];

    assign byte_valid_i = 1'b1;
    assign byte_data_i  = src_mem[4'(src_idx - src_base)];
    assign byte_err_i   = ((src_idx - src_base) == err_pos);

    always @(negedge clk) begin
        if (pend) begin src_idx++; pend = 0; end
        if (byte_ready_o && byte_valid_i) pend = 1;
        if (cclk_o && !cclk_prev) begin
            bits[nbits % 512] = din_o; nbits++; pulses++;
        end
        if (cclk_o) hi_run++;
        else if (cclk_prev) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (!prog_n_o) begin
            prog_low++;
            if (prog_prev) prog_falls++;
            phi = 0;
        end else phi++;
        if (busy_o && prog_n_o) wait_cnt++;
        cclk_prev = cclk_o;
        prog_prev = prog_n_o;
        init_i = init_en && (phi >= 6);
        done_i = done_en && ((pulses - done_base) >= done_after);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy_o; k++) begin
            @(negedge clk); #1;
        end
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic kick(input int len);
        @(negedge clk);
        byte_len_i = LW'(len);
        start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    endtask

    function automatic int bit_errs(input int b0, input int nb);
        int e = 0;
        for (int i = 0; i < nb; i++)
            if (bits[(b0 + i) % 512] !== src_mem[i / 8][7 - (i % 8)]) e++;
        return e;
    endfunction

    task automatic t_reset();
        chk(prog_n_o == 1 && cclk_o == 0 && din_o == 0, "R1 idle pins",
            {prog_n_o, cclk_o, din_o}, 3'b100);
        chk(busy_o == 0 && success_o == 0 && error_o == 0, "R1 flags",
            {busy_o, success_o, error_o}, 0);
    endtask

    task automatic t_normal();
        int p0, b0, pl0, pf0;
        src_mem[0] = 8'hA5; src_mem[1] = 8'h3C; src_mem[2] = 8'h01;
        src_base = src_idx; err_pos = -1; init_en = 1;
        p0 = pulses; b0 = nbits; pl0 = prog_low; pf0 = prog_falls;
        done_base = pulses; done_after = 27; done_en = 1;
        hi_min = 1000; hi_max = 0;
        kick(3);
        wait_idle();
        chk(prog_low - pl0 == PH, "R2 program low cycles", prog_low - pl0, PH);
        chk(prog_falls - pf0 == 1, "R2 program pulses", prog_falls - pf0, 1);
        chk(bit_errs(b0, 24) == 0, "R4 MSB-first bits", bit_errs(b0, 24), 0);
        chk(hi_min == HP && hi_max == HP, "R4 clock high width", hi_max, HP);
        chk(src_idx - src_base == 3, "R5 bytes taken", src_idx - src_base, 3);
        chk((pulses - p0) >= 27 && (pulses - p0) <= 29, "R6 pulses until done",
            pulses - p0, 27);
        chk(success_o == 1 && error_o == 0, "R6 success", success_o, 1);
        done_en = 0;
    endtask

    task automatic t_init_timeout();
        int p0, w0;
        src_base = src_idx; err_pos = -1; init_en = 0; done_en = 0;
        p0 = pulses; w0 = wait_cnt;
        kick(2);
        wait_idle();
        chk(error_o == 1 && success_o == 0, "R3 init timeout error", error_o, 1);
        chk(wait_cnt - w0 == IL, "R3 init wait cycles", wait_cnt - w0, IL);
        chk(pulses == p0, "R3 no clock without init", pulses - p0, 0);
        chk(src_idx == src_base, "R3 no byte taken", src_idx - src_base, 0);
        init_en = 1;
    endtask

    task automatic t_done_timeout();
        int p0, b0;
        src_mem[0] = 8'hC3;
        src_base = src_idx; err_pos = -1; done_en = 0;
        p0 = pulses; b0 = nbits;
        kick(1);
        wait_idle();
        chk(pulses - p0 == 8 + DL, "R7 pulses before timeout", pulses - p0, 8 + DL);
        chk(error_o == 1 && success_o == 0, "R7 done timeout error", error_o, 1);
        chk(bit_errs(b0, 8) == 0, "R4 byte C3 bits", bit_errs(b0, 8), 0);
    endtask

    task automatic t_abort();
        int p0, b0;
        src_mem[0] = 8'h6E; src_mem[1] = 8'hFF; src_mem[2] = 8'h12; src_mem[3] = 8'h34;
        src_base = src_idx; err_pos = 1;
        done_base = pulses; done_after = 0; done_en = 1;
        p0 = pulses; b0 = nbits;
        kick(4);
        wait_idle();
        chk(pulses - p0 == 8, "R8 only first byte clocked", pulses - p0, 8);
        chk(src_idx - src_base == 2, "R8 taking stops at error", src_idx - src_base, 2);
        chk(bit_errs(b0, 8) == 0, "R8 first byte bits", bit_errs(b0, 8), 0);
        chk(success_o == 1, "R8 reaches done wait", success_o, 1);
        err_pos = -1; done_en = 0;
    endtask

    task automatic t_zero_len();
        int p0;
        src_base = src_idx; err_pos = -1;
        done_base = pulses; done_after = 3; done_en = 1;
        p0 = pulses;
        kick(0);
        wait_idle();
        chk(src_idx == src_base, "R10 no byte taken", src_idx - src_base, 0);
        chk((pulses - p0) >= 3 && (pulses - p0) <= 5, "R10 done clocking only",
            pulses - p0, 3);
        chk(success_o == 1, "R10 success", success_o, 1);
        done_en = 0;
    endtask

    task automatic t_restart_ignored();
        int b0, pf0;
        src_mem[0] = 8'h80; src_mem[1] = 8'h01;
        src_base = src_idx; err_pos = -1;
        done_base = pulses; done_after = 16; done_en = 1;
        b0 = nbits; pf0 = prog_falls;
        kick(2);
        repeat (25) @(negedge clk);
        start_i = 1'b1;
        byte_len_i = 8'd9;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        chk(prog_falls - pf0 == 1, "R9 single program pulse", prog_falls - pf0, 1);
        chk(src_idx - src_base == 2, "R9 byte count kept", src_idx - src_base, 2);
        chk(bit_errs(b0, 16) == 0, "R9 bits unchanged", bit_errs(b0, 16), 0);
        chk(success_o == 1, "R9 completes", success_o, 1);
        done_en = 0;
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_normal();
        t_init_timeout();
        t_done_timeout();
        t_abort();
        t_zero_len();
        t_restart_ignored();
        t_reset_after();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic t_reset_after();
        chk(prog_n_o == 1 && cclk_o == 0 && din_o == 0 && busy_o == 0,
            "R1 idle pins after run", {prog_n_o, cclk_o, din_o, busy_o}, 4'b1000);
    endtask
endmodule